// File: doc/BRIEF.md
# Buffered-update PWM channel

This block is one pulse-width-modulated output channel with a complementary pair of drive pins. A period counter advances on each clock-enable tick and wraps at the active period. The raw waveform is high at the start of each period while the count is below the active duty value. Two drive pins are built from it, one following the raw level and one following its inverse, and each pin's rising edge is held back by a programmable dead time.

Software never writes the active period, duty or dead times directly. Each write lands in a shadow register and raises a pending flag. The active set is loaded from the shadows only at a period boundary, and a commit policy decides which boundary:
- A free-running (asynchronous) channel commits at the next boundary.
- A grouped (synchronous) channel in manual mode commits only after an unlock request.
- In the two automatic modes, period and dead times still need the unlock request, but duty commits at the boundary that closes an update interval counted in periods.

Top module: `pwm_buffered_chan`

## Requirements
- R1: After synchronous reset the active period is 16, the duty is 8 and both dead times are 0, with no update pending. The first period is therefore 16 ticks long, with 8 ticks of high-side drive and 8 ticks of low-side drive.
- R2: The count advances only on a cycle with `tick` high, runs 0 to P-1 for an active period P, and returns to 0 after P-1. `period_end` is high exactly in the cycle where `tick` is high and the count is P-1. Without ticks, `period_end` stays low and the pins hold.
- R3: The raw waveform is high while the count is below the active duty D, so with zero dead time `pwm_hi` is high for D ticks of each period. Legal duty values are 1 to P-1.
- R4: With `sync_en` = 0, pending period, duty and dead-time values are loaded at the next `period_end`, whatever the value of `upd_mode`.
- R5: When a shadow register is written more than once before a commit, only the last value written is loaded.
- R6: With `sync_en` = 1 and `upd_mode` = 0, pending values stay pending until an `unlock` pulse has been seen, and are then loaded at the next `period_end`. The unlock request is consumed at that boundary, so a later write again waits for a new unlock.
- R7: With `sync_en` = 1 and `upd_mode` = 1 or 2, a pending period or dead-time value is loaded only at a `period_end` that comes after an `unlock` pulse. Value 3 of `upd_mode` behaves as 1.
- R8: With `sync_en` = 1 and `upd_mode` = 1 or 2, a pending duty needs no unlock. An interval counter counts period ends and returns to 0 when it equals `upd_period`. The duty is loaded at the `period_end` where the counter equals `upd_period`: at every boundary for `upd_period` = 0, and at every third boundary for `upd_period` = 2.
- R9: `pwm_hi` rises a number of ticks after the raw rise equal to the active high-side dead time (`dead_hi`), and `pwm_lo` rises after the raw fall delayed by the active low-side dead time (`dead_lo`). Per period, `pwm_hi` is high for max(0, D - `dead_hi`) ticks and `pwm_lo` for max(0, P - D - `dead_lo`) ticks. The two pins are never high together.
- R10: A write strobe in the same cycle as `period_end` stays pending for the following boundary, and the old pending value, if any, is the one loaded. An `unlock` pulse in the same cycle as `period_end` counts for that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable for the period counter and dead-time counters |
| wr_period | input | 1 | Write strobe for the period shadow |
| period_wdata | input | 16 | New period value |
| wr_duty | input | 1 | Write strobe for the duty shadow |
| duty_wdata | input | 16 | New duty value |
| wr_dead | input | 1 | Write strobe for both dead-time shadows |
| dead_hi_wdata | input | 8 | New high-side dead time in ticks |
| dead_lo_wdata | input | 8 | New low-side dead time in ticks |
| sync_en | input | 1 | 1 places the channel in a synchronous group |
| upd_mode | input | 2 | Commit method for a synchronous channel (0 manual, 1 or 2 automatic duty) |
| unlock | input | 1 | Pulse requesting a gated commit |
| upd_period | input | 4 | Number of period ends that closes an automatic duty interval |
| pwm_hi | output | 1 | High-side drive |
| pwm_lo | output | 1 | Low-side drive |
| period_end | output | 1 | One-cycle pulse on the last tick of each period |

## Verification
Two pairs of events can land in the same clock edge and need a defined winner. The first pair is a shadow write and a period-boundary commit. The second is an unlock pulse and the boundary it is meant to release. The bench provokes each collision by waiting for the cycle in which `period_end` is high and driving the write strobe or the unlock pulse in exactly that cycle. It judges the result by measuring the high-side pulse width over the next two whole periods. A write that collides must show its old duty for one more period and the new one after that. An unlock that collides must release the pending duty at once.

// File: rtl/pwm_upd_pkg.sv
package pwm_upd_pkg;

    localparam int CNT_W      = 16;
    localparam int DT_W       = 8;
    localparam int UPR_W      = 4;
    localparam int RST_PERIOD = 16;
    localparam int RST_DUTY   = 8;
    localparam int N_SIDES    = 2;

    typedef enum logic [1:0] {
        UPD_MANUAL = 2'd0,
        UPD_AUTO_A = 2'd1,
        UPD_AUTO_B = 2'd2,
        UPD_AUTO_C = 2'd3
    } upd_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic [DT_W-1:0]  dead_hi;
        logic [DT_W-1:0]  dead_lo;
    } pwm_cfg_t;

    function automatic pwm_cfg_t reset_cfg();
        pwm_cfg_t c;
        c.period  = CNT_W'(RST_PERIOD);
        c.duty    = CNT_W'(RST_DUTY);
        c.dead_hi = '0;
        c.dead_lo = '0;
        return c;
    endfunction

    // Automatic modes gate only the duty on the interval counter.
    function automatic logic duty_on_interval(input logic sync, input upd_mode_e m);
        return sync && (m != UPD_MANUAL);
    endfunction

endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
    import pwm_upd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_period,
    input  logic [CNT_W-1:0] period_wdata,
    input  logic             wr_duty,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             wr_dead,
    input  logic [DT_W-1:0]  dead_hi_wdata,
    input  logic [DT_W-1:0]  dead_lo_wdata,
    input  logic             sync_en,
    input  upd_mode_e        mode,
    input  logic             unlock,
    input  logic [UPR_W-1:0] upd_period,
    input  logic             period_end,
    output pwm_cfg_t         act
);

    pwm_cfg_t         shadow;
    logic             pend_per, pend_duty, pend_dead;
    logic             unlock_q;
    logic [UPR_W-1:0] ivl_cnt;

    logic eff_unlock, ivl_match, auto_duty;
    logic take_per, take_duty, take_dead, consume_unlock;

    always_comb begin
        eff_unlock     = unlock_q | unlock;
        ivl_match      = (ivl_cnt == upd_period);
        auto_duty      = duty_on_interval(sync_en, mode);
        take_per       = period_end && pend_per  && (!sync_en || eff_unlock);
        take_dead      = period_end && pend_dead && (!sync_en || eff_unlock);
        take_duty      = period_end && pend_duty &&
                         (!sync_en || (auto_duty ? ivl_match : eff_unlock));
        consume_unlock = period_end && sync_en && eff_unlock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act       <= reset_cfg();
            shadow    <= reset_cfg();
            pend_per  <= 1'b0;
            pend_duty <= 1'b0;
            pend_dead <= 1'b0;
            unlock_q  <= 1'b0;
            ivl_cnt   <= '0;
        end else begin
            if (take_per)  act.period <= shadow.period;
            if (take_duty) act.duty   <= shadow.duty;
            if (take_dead) begin
                act.dead_hi <= shadow.dead_hi;
                act.dead_lo <= shadow.dead_lo;
            end

            if (wr_period) begin
                shadow.period <= period_wdata;
                pend_per      <= 1'b1;
            end else if (take_per) begin
                pend_per <= 1'b0;
            end

            if (wr_duty) begin
                shadow.duty <= duty_wdata;
                pend_duty   <= 1'b1;
            end else if (take_duty) begin
                pend_duty <= 1'b0;
            end

            if (wr_dead) begin
                shadow.dead_hi <= dead_hi_wdata;
                shadow.dead_lo <= dead_lo_wdata;
                pend_dead      <= 1'b1;
            end else if (take_dead) begin
                pend_dead <= 1'b0;
            end

            if (consume_unlock) unlock_q <= 1'b0;
            else if (unlock)    unlock_q <= 1'b1;

            if (period_end) ivl_cnt <= ivl_match ? '0 : ivl_cnt + 1'b1;
        end
    end

    // R4
    commit_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(act));

    // R6
    manual_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_en && mode == UPD_MANUAL && !unlock_q && !unlock) |=> $stable(act));

    // R8
    duty_interval_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_en && mode != UPD_MANUAL && !ivl_match) |=> $stable(act.duty));

    // R6
    unlock_consumed_chk: assert property (@(posedge clk) disable iff (rst)
        (period_end && sync_en && (unlock_q || unlock)) |=> !unlock_q);

endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen
    import pwm_upd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             period_end,
    output logic             raw
);

    logic [CNT_W-1:0] cnt;
    logic             last;

    always_comb begin
        last       = (cnt >= period - 1'b1);
        period_end = tick && last;
        raw        = (cnt < duty);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= last ? '0 : cnt + 1'b1;
    end

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        period_end |=> (cnt == '0));

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < period);

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/pwm_edge_delay.sv
module pwm_edge_delay
    import pwm_upd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            level_in,
    input  logic [DT_W-1:0] delay,
    output logic            level_out
);

    logic [DT_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || !level_in)          run <= '0;
        else if (tick && run < delay)  run <= run + 1'b1;
    end

    assign level_out = level_in && (run >= delay);

    // R9
    rise_held_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(level_in) && delay != '0) |-> !level_out);

endmodule

// File: rtl/pwm_buffered_chan.sv
module pwm_buffered_chan
    import pwm_upd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_period,
    input  logic [CNT_W-1:0] period_wdata,
    input  logic             wr_duty,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             wr_dead,
    input  logic [DT_W-1:0]  dead_hi_wdata,
    input  logic [DT_W-1:0]  dead_lo_wdata,
    input  logic             sync_en,
    input  logic [1:0]       upd_mode,
    input  logic             unlock,
    input  logic [UPR_W-1:0] upd_period,
    output logic             pwm_hi,
    output logic             pwm_lo,
    output logic             period_end
);

    pwm_cfg_t        act;
    logic            raw;
    logic            side_in  [N_SIDES];
    logic [DT_W-1:0] side_dly [N_SIDES];
    logic            side_out [N_SIDES];

    pwm_shadow_bank u_bank (
        .clk           (clk),
        .rst           (rst),
        .wr_period     (wr_period),
        .period_wdata  (period_wdata),
        .wr_duty       (wr_duty),
        .duty_wdata    (duty_wdata),
        .wr_dead       (wr_dead),
        .dead_hi_wdata (dead_hi_wdata),
        .dead_lo_wdata (dead_lo_wdata),
        .sync_en       (sync_en),
        .mode          (upd_mode_e'(upd_mode)),
        .unlock        (unlock),
        .upd_period    (upd_period),
        .period_end    (period_end),
        .act           (act)
    );

    pwm_period_gen u_gen (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .period     (act.period),
        .duty       (act.duty),
        .period_end (period_end),
        .raw        (raw)
    );

    always_comb begin
        side_in[0]  = raw;
        side_in[1]  = !raw;
        side_dly[0] = act.dead_hi;
        side_dly[1] = act.dead_lo;
    end

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        pwm_edge_delay u_dly (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .level_in  (side_in[s]),
            .delay     (side_dly[s]),
            .level_out (side_out[s])
        );
    end

    assign pwm_hi = side_out[0];
    assign pwm_lo = side_out[1];

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(pwm_hi && pwm_lo));

endmodule

// File: tb/sim_pwm_buffered_chan.sv
module sim_pwm_buffered_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_period = 1'b0, wr_duty = 1'b0, wr_dead = 1'b0;
    logic [15:0] period_wdata = '0, duty_wdata = '0;
    logic [7:0]  dead_hi_wdata = '0, dead_lo_wdata = '0;
    logic        sync_en = 1'b0;
    logic [1:0]  upd_mode = 2'd0;
    logic        unlock = 1'b0;
    logic [3:0]  upd_period = 4'd0;
    logic        pwm_hi, pwm_lo, period_end;

    int checks = 0;
    int failures = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_buffered_chan u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .wr_period(wr_period), .period_wdata(period_wdata),
        .wr_duty(wr_duty), .duty_wdata(duty_wdata),
        .wr_dead(wr_dead), .dead_hi_wdata(dead_hi_wdata), .dead_lo_wdata(dead_lo_wdata),
        .sync_en(sync_en), .upd_mode(upd_mode), .unlock(unlock), .upd_period(upd_period),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .period_end(period_end)
    );

    // {period, duty, dead_hi, dead_lo, expected hi ticks, expected lo ticks}
    localparam int NV = 6;
    localparam int VEC [NV][6] = '{
        '{10,  3, 1, 2,  2, 5},
        '{20, 19, 4, 0, 15, 1},
        '{ 8,  1, 0, 3,  1, 4},
        '{12,  6, 7, 1,  0, 5},
        '{ 6,  5, 2, 2,  3, 0},
        '{16,  8, 0, 0,  8, 8}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drop_strobes();
        wr_period = 1'b0; wr_duty = 1'b0; wr_dead = 1'b0; unlock = 1'b0;
    endtask

    task automatic sync_end();
        do begin
            @(negedge clk);
            drop_strobes();
        end while (!period_end);
    endtask

    // Counts one whole period starting with the cycle after the current one.
    task automatic measure(output int len, output int hi, output int lo);
        len = 0; hi = 0; lo = 0;
        do begin
            @(negedge clk);
            drop_strobes();
            len++;
            if (pwm_hi) hi++;
            if (pwm_lo) lo++;
            if (pwm_hi && pwm_lo) overlap++;
        end while (!period_end);
    endtask

    task automatic away_from_end();
        @(negedge clk);
        drop_strobes();
        while (period_end) begin
            @(negedge clk);
            drop_strobes();
        end
    endtask

    task automatic write_cfg(input bit wp, input int p, input bit wd, input int d,
                             input bit wt, input int h, input int l);
        away_from_end();
        wr_period = wp; period_wdata = 16'(p);
        wr_duty = wd;   duty_wdata = 16'(d);
        wr_dead = wt;   dead_hi_wdata = 8'(h); dead_lo_wdata = 8'(l);
        @(negedge clk);
        drop_strobes();
    endtask

    task automatic pulse_unlock();
        away_from_end();
        unlock = 1'b1;
        @(negedge clk);
        drop_strobes();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int len, hi, lo;
        bit held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state: count 0 below duty 8, dead times 0
        chk("R1 reset pwm_hi", int'(pwm_hi), 1);
        chk("R1 reset pwm_lo", int'(pwm_lo), 0);
        chk("R1 reset period_end", int'(period_end), 0);

        // R2 no tick: nothing moves
        held = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (period_end || !pwm_hi || pwm_lo) held = 1'b0;
        end
        chk("R2 hold without tick", int'(held), 1);

        tick = 1'b1;
        sync_end();
        measure(len, hi, lo);
        chk("R1 reset period length", len, 16);
        chk("R1 reset hi ticks", hi, 8);
        chk("R1 reset lo ticks", lo, 8);

        // R3 R4 R9 R2 table of free-running configurations, mode ignored
        upd_mode = 2'd2;
        for (int v = 0; v < NV; v++) begin
            write_cfg(1, VEC[v][0], 1, VEC[v][1], 1, VEC[v][2], VEC[v][3]);
            sync_end();
            measure(len, hi, lo);
            chk($sformatf("R2 vec%0d length", v), len, VEC[v][0]);
            chk($sformatf("R3 R9 vec%0d hi ticks", v), hi, VEC[v][4]);
            chk($sformatf("R9 vec%0d lo ticks", v), lo, VEC[v][5]);
        end
        upd_mode = 2'd0;

        // R5 last write wins
        write_cfg(0, 0, 1, 3, 0, 0, 0);
        write_cfg(0, 0, 1, 5, 0, 0, 0);
        sync_end();
        measure(len, hi, lo);
        chk("R5 last duty write", hi, 5);

        // R10 write on the boundary cycle waits one more period
        do @(negedge clk); while (!period_end);
        wr_duty = 1'b1; duty_wdata = 16'd11;
        measure(len, hi, lo);
        chk("R10 colliding write not yet active", hi, 5);
        measure(len, hi, lo);
        chk("R10 colliding write next period", hi, 11);

        // R6 manual synchronous mode
        sync_en = 1'b1; upd_mode = 2'd0;
        write_cfg(1, 10, 1, 4, 0, 0, 0);
        sync_end();
        measure(len, hi, lo);
        chk("R6 held length without unlock", len, 16);
        chk("R6 held duty without unlock", hi, 11);
        pulse_unlock();
        sync_end();
        measure(len, hi, lo);
        chk("R6 length after unlock", len, 10);
        chk("R6 duty after unlock", hi, 4);
        write_cfg(0, 0, 1, 7, 0, 0, 0);
        sync_end();
        measure(len, hi, lo);
        chk("R6 unlock consumed", hi, 4);

        // R10 unlock on the boundary cycle counts for that boundary
        do @(negedge clk); while (!period_end);
        unlock = 1'b1;
        measure(len, hi, lo);
        chk("R10 colliding unlock", hi, 7);

        // R8 automatic duty with interval 0 needs no unlock
        upd_mode = 2'd1;
        write_cfg(0, 0, 1, 3, 0, 0, 0);
        sync_end();
        measure(len, hi, lo);
        chk("R8 interval 0 duty", hi, 3);
        @(negedge clk);
        upd_period = 4'd2;
        // R7 R8 period waits for unlock, duty waits for third boundary
        write_cfg(1, 12, 1, 6, 0, 0, 0);
        sync_end();
        measure(len, hi, lo);
        chk("R8 interval 2 first period", hi, 3);
        measure(len, hi, lo);
        chk("R8 interval 2 second period", hi, 3);
        measure(len, hi, lo);
        chk("R8 interval 2 third period", hi, 6);
        chk("R7 period held in auto mode", len, 10);
        pulse_unlock();
        sync_end();
        measure(len, hi, lo);
        chk("R7 period after unlock", len, 12);

        // R7 mode 2 period gating
        upd_mode = 2'd2;
        write_cfg(1, 16, 0, 0, 0, 0, 0);
        sync_end();
        measure(len, hi, lo);
        chk("R7 mode2 period held", len, 12);
        pulse_unlock();
        sync_end();
        measure(len, hi, lo);
        chk("R7 mode2 period after unlock", len, 16);

        chk("R9 pins never high together", overlap, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule